// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block pairs a behavioural single-port synchronous SRAM with the client sequencer that drives it. Both share one data bus. Each cycle the client may present one command: a read, a write, or nothing. The SRAM samples enable, write select and address on the rising edge. Read data comes out of an output register. Write data is handed over late, in the same slot where read data would have appeared. Because of this, a read slot and a write slot never compete for the bus, and any order of reads and writes can run on consecutive cycles.

A command issued in cycle n has its data slot in cycle n+2. For a read, the SRAM drives the bus and the client reports the word on `rd_data`. For a write, the client drives the bus with the word it captured at issue, and the SRAM stores it at the end of that cycle. A read issued one cycle after a write to the same address would sample the array before that write lands. The SRAM covers this case by forwarding the word that is on the bus at that moment. The bus is modelled as an explicit multiplexer: each side has its own drive flag, and the bus reads zero when neither side drives.

Top module: `zbt_sram_sys`

## Requirements
- R1: While reset is asserted, and in the first two cycles after it, `rd_valid`, `client_drive` and `sram_drive` are 0 and `bus_data` is 0. Every storage word reads back as 0 until it is written.
- R2: A read issued in cycle n (`cmd_en`=1, `cmd_we`=0) gives `rd_valid`=1 in cycle n+2 and in no other cycle. In that cycle `rd_data` holds the word at `cmd_addr` as left by all earlier commands.
- R3: A write issued in cycle n (`cmd_en`=1, `cmd_we`=1) makes the client drive `bus_data` with the `cmd_wdata` sampled in cycle n, during cycle n+2 only. The word is stored at `cmd_addr` at the end of cycle n+2.
- R4: A command is accepted in every cycle. Any mix of reads and writes issued on consecutive cycles yields, for every read, the same data as if the commands had run one at a time in issue order.
- R5: A read issued in the cycle right after a write to the same address returns the new write data.
- R6: The SRAM drives the bus only in read data slots and the client only in write data slots. The two never drive in the same cycle, and the bus reads 0 when idle.
- R7: A cycle with `cmd_en`=0 is a bubble. Two cycles later no side drives and `rd_valid`=0, and no word is changed, whatever `cmd_we`, `cmd_addr` and `cmd_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_en | input | 1 | Command present this cycle |
| cmd_we | input | 1 | 1 = write, 0 = read (when cmd_en=1) |
| cmd_addr | input | AW | Word address of the command |
| cmd_wdata | input | DW | Write word, sampled with the command |
| rd_valid | output | 1 | Read data slot this cycle |
| rd_data | output | DW | Read word (0 when rd_valid=0) |
| bus_data | output | DW | Value on the shared data bus |
| client_drive | output | 1 | Client is driving the bus |
| sram_drive | output | 1 | SRAM output register is driving the bus |

## Verification
Several properties are checked on every cycle:
- the two sides never drive the bus together;
- the SRAM's drive slot matches the client's read slot;
- every drive slot traces back to a command of the matching kind two cycles earlier;
- a bubble produces no slot;
- a forwarded read returns exactly the word that was on the bus.

Whether the stored words are correct can only be shown by the bench's scenarios. These cover unwritten contents after reset, read-after-write at distances one and two, a read/write interleave with no idle cycles, bubbles carrying stray write data, and a long pseudo-random stream. Each of these is compared against a sequential memory model.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
   // Cycles from command edge to its data slot on the bus
   localparam int ZBT_LAT = 2;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } zbt_op_e;

   function automatic zbt_op_e zbt_decode(input logic en, input logic we);
      if (!en)     return OP_IDLE;
      else if (we) return OP_WRITE;
      else         return OP_READ;
   endfunction
endpackage

// File: rtl/zbt_delay_line.sv
module zbt_delay_line #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [W-1:0]          din,
   output logic [STAGES*W-1:0]   taps
);
   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= '0;
            else        st[i] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
         end
      end
      assign taps[i*W +: W] = st[i];
   end
endmodule

// File: rtl/zbt_client.sv
module zbt_client
   import zbt_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_en,
   input  logic          cmd_we,
   input  logic [AW-1:0] cmd_addr,
   input  logic [DW-1:0] cmd_wdata,
   input  logic [DW-1:0] bus_in,
   output logic          mem_ce,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic          drive,
   output logic [DW-1:0] drive_data,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data
);
   localparam int EW = 2 + DW;

   logic [ZBT_LAT*EW-1:0] taps;
   logic [EW-1:0]         last;
   zbt_op_e               slot_op;

   // Command pins go straight to the SRAM; it samples them on the edge
   assign mem_ce   = cmd_en;
   assign mem_we   = cmd_we;
   assign mem_addr = cmd_addr;

   zbt_delay_line #(.W(EW), .STAGES(ZBT_LAT)) u_track (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({2'(zbt_decode(cmd_en, cmd_we)), cmd_wdata}),
      .taps (taps)
   );

   assign last       = taps[(ZBT_LAT-1)*EW +: EW];
   assign slot_op    = zbt_op_e'(last[EW-1 -: 2]);
   assign drive      = (slot_op == OP_WRITE);
   assign drive_data = last[DW-1:0];
   assign rd_valid   = (slot_op == OP_READ);
   assign rd_data    = rd_valid ? bus_in : '0;

   // R3
   write_slot_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> $past(cmd_en && cmd_we, 2));
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
   import zbt_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] bus_in,
   output logic          q_drive,
   output logic [DW-1:0] q_data
);
   localparam int DEPTH = 1 << AW;
   localparam int CW    = 2 + AW;

   logic [ZBT_LAT*CW-1:0] taps;
   zbt_op_e               op1, op2;
   logic [AW-1:0]         a1, a2;
   logic [DW-1:0]         mem [DEPTH];
   logic [DW-1:0]         q_reg;
   logic                  fwd;

   zbt_delay_line #(.W(CW), .STAGES(ZBT_LAT)) u_cmd (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({2'(zbt_decode(ce, we)), addr}),
      .taps (taps)
   );

   assign op1 = zbt_op_e'(taps[CW-1 -: 2]);
   assign a1  = taps[AW-1:0];
   assign op2 = zbt_op_e'(taps[2*CW-1 -: 2]);
   assign a2  = taps[CW +: AW];

   // Write one cycle ahead lands on the same edge the read samples
   assign fwd = (op2 == OP_WRITE) && (a2 == a1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (op2 == OP_WRITE) begin
         mem[a2] <= bus_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              q_reg <= '0;
      else if (op1 == OP_READ) q_reg <= fwd ? bus_in : mem[a1];
   end

   assign q_drive = (op2 == OP_READ);
   assign q_data  = q_reg;

   // R5
   forward_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op1 == OP_READ && op2 == OP_WRITE && a1 == a2) |=> (q_drive && q_data == $past(bus_in)));
endmodule

// File: rtl/zbt_sram_sys.sv
module zbt_sram_sys #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_en,
   input  logic          cmd_we,
   input  logic [AW-1:0] cmd_addr,
   input  logic [DW-1:0] cmd_wdata,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] bus_data,
   output logic          client_drive,
   output logic          sram_drive
);
   logic          m_ce, m_we;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] c_data, s_data;

   zbt_client #(.AW(AW), .DW(DW)) u_client (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_en    (cmd_en),
      .cmd_we    (cmd_we),
      .cmd_addr  (cmd_addr),
      .cmd_wdata (cmd_wdata),
      .bus_in    (bus_data),
      .mem_ce    (m_ce),
      .mem_we    (m_we),
      .mem_addr  (m_addr),
      .drive     (client_drive),
      .drive_data(c_data),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   zbt_sram_core #(.AW(AW), .DW(DW)) u_sram (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce     (m_ce),
      .we     (m_we),
      .addr   (m_addr),
      .bus_in (bus_data),
      .q_drive(sram_drive),
      .q_data (s_data)
   );

   // Shared bus: whichever side holds the slot drives, else released (0)
   assign bus_data = client_drive ? c_data : (sram_drive ? s_data : '0);

   // R6
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(client_drive && sram_drive));

   // R2
   read_slot_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == sram_drive);

   // R7
   bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cmd_en, 2) |-> (!sram_drive && !client_drive));
endmodule

// File: tb/zbt_sram_sys_tb.sv
module zbt_sram_sys_tb_top;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int CLK_PERIOD = 10;
   localparam int CMDW = 2 + AW + DW;
   localparam int WATCHDOG = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_en = 1'b0, cmd_we = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          rd_valid, client_drive, sram_drive;
   logic [DW-1:0] rd_data, bus_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   logic [CMDW-1:0] hist[$];
   logic [DW-1:0]   model [1<<AW];
   logic [CMDW-1:0] prev_cmd = '0;
   string           phase_tag = "R2";
   int unsigned     seed = 32'h1357_9bdf;

   always #(CLK_PERIOD/2) clk = ~clk;

   zbt_sram_sys #(.AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_we(cmd_we),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
      .rd_data(rd_data), .bus_data(bus_data), .client_drive(client_drive),
      .sram_drive(sram_drive)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   task automatic expect_quiet(input string tag);
      chk(tag, "rd_valid", int'(rd_valid), 0);
      chk(tag, "client_drive", int'(client_drive), 0);
      chk(tag, "sram_drive", int'(sram_drive), 0);
      chk(tag, "bus_data", int'(bus_data), 0);
      chk(tag, "rd_data", int'(rd_data), 0);
   endtask

   // Compare the slot of the command issued two cycles ago with the model
   task automatic compare();
      logic [CMDW-1:0] c;
      logic en, we;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      string tg;
      if (hist.size() < 2) begin
         expect_quiet("R1");
         return;
      end
      c  = hist.pop_front();
      en = c[CMDW-1];
      we = c[CMDW-2];
      a  = c[DW +: AW];
      d  = c[DW-1:0];
      if (!en) begin
         expect_quiet("R7");
      end else if (we) begin
         chk("R3", "client_drive", int'(client_drive), 1);
         chk("R3", "bus_data", int'(bus_data), int'(d));
         chk("R6", "sram_drive", int'(sram_drive), 0);
         chk("R3", "rd_valid", int'(rd_valid), 0);
         model[a] = d;
      end else begin
         tg = (prev_cmd[CMDW-1] && prev_cmd[CMDW-2] && prev_cmd[DW +: AW] == a) ? "R5" : phase_tag;
         chk(tg, "rd_valid", int'(rd_valid), 1);
         chk(tg, "rd_data", int'(rd_data), int'(model[a]));
         chk("R6", "sram_drive", int'(sram_drive), 1);
         chk("R6", "client_drive", int'(client_drive), 0);
      end
      prev_cmd = c;
   endtask

   task automatic step(input logic en, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      compare();
      cmd_en = en; cmd_we = we; cmd_addr = a; cmd_wdata = d;
      hist.push_back({en, we, a, d});
   endtask

   task automatic rd(input logic [AW-1:0] a);
      step(1'b1, 1'b0, a, DW'(8'h5a));
   endtask
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      step(1'b1, 1'b1, a, d);
   endtask
   task automatic idle();
      step(1'b0, 1'b0, '0, '0);
   endtask

   function automatic int unsigned nxt(input int unsigned s);
      int unsigned x = s;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      return x;
   endfunction

   initial begin
      for (int i = 0; i < (1<<AW); i++) model[i] = '0;
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      expect_quiet("R1");
      rst_n = 1'b1;
      // R1: unwritten words read as zero
      phase_tag = "R1";
      rd(4'd3); rd(4'd9); idle(); idle();
      // R2: plain writes then spaced reads
      phase_tag = "R2";
      for (int i = 0; i < 6; i++) wr(AW'(i), DW'(8'h10 + i * 7));
      idle();
      for (int i = 0; i < 6; i++) begin rd(AW'(5 - i)); idle(); end
      // R4: back-to-back mix R,R,W,R,W,R,R,W,W,R
      phase_tag = "R4";
      rd(4'd1); rd(4'd2); wr(4'd7, 8'hc3); rd(4'd7); wr(4'd2, 8'h99);
      rd(4'd2); rd(4'd7); wr(4'd1, 8'h3c); wr(4'd1, 8'h3d); rd(4'd1);
      // R5: read one cycle after write; also distance two
      wr(4'd12, 8'hee); rd(4'd12);
      wr(4'd13, 8'h41); rd(4'd0); rd(4'd13);
      // R7: bubbles with stray write data, then read back untouched words
      phase_tag = "R7";
      step(1'b0, 1'b1, 4'd12, 8'h00);
      step(1'b0, 1'b1, 4'd13, 8'hff);
      step(1'b0, 1'b0, 4'd2, 8'h77);
      rd(4'd12); idle(); rd(4'd13); step(1'b0, 1'b1, 4'd2, 8'h01); rd(4'd2);
      // R4: long pseudo-random stream with occasional bubbles
      phase_tag = "R4";
      for (int i = 0; i < 400; i++) begin
         seed = nxt(seed);
         step(seed[0] | seed[1] | seed[2], seed[3], seed[7:4], seed[15:8]);
      end
      idle(); idle(); idle();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end
endmodule